// File: doc/BRIEF.md
# Phased Control-Point Sequencer

This block runs a self-test session over the logic it wraps. The session has four phases, numbered 0 to 3, and the same number of test patterns is applied in every phase. In each phase a different group of forcing gates is switched on: some lines are held at 0 through AND-type cells and others at 1 through OR-type cells. Which cells force in which phase is set per cell by a four-bit phase mask parameter, so the forcing groups change from phase to phase. A single global test-mode enable would switch every cell at once.

A start pulse loads the pattern count and begins phase 0. An internal counter treats one clock cycle as one pattern. When a phase has used up its patterns, the phase number moves on. When phase 3 ends, the session stops and a done flag rises. Outside a session every cell is transparent, so the functional lines pass through unchanged. The functional lines are combinational pass-through wires with no handshake. Control and status pins are plain levels and pulses, so there is no back-pressure to manage.

Top module: `cpt_session_ctrl`

## Requirements
- R1: After reset the block is idle: `active_o`=0, `phase_o`=0, `done_o`=0.
- R2: A `start_i` high at a clock edge while idle (including after done) loads `pat_count_i`, sets `active_o`=1 and `phase_o`=0, and clears `done_o`. A `start_i` during an active session is ignored, and `pat_count_i` is sampled only at that start edge.
- R3: While active, each phase lasts N clock cycles, where N is the loaded count and a count of 0 is treated as 1. The phases run in the order 0, 1, 2, 3.
- R4: At the edge that ends the last pattern of phase 3, `active_o` falls and `done_o` rises together. `phase_o` then stays at 3 and `done_o` stays at 1 until the next accepted start.
- R5: An AND-type cell drives its output equal to its input when its test signal is 1, and drives 0 when the signal is 0.
- R6: An OR-type cell drives its output equal to its input when its test signal is 0, and drives 1 when the signal is 1.
- R7: When not active, every AND test signal is 1 and every OR test signal is 0, so all outputs equal their inputs.
- R8: While active, a cell forces when bit p of its phase mask is set, where p is the current phase. Cell i's mask is bits [4i+3:4i] of its map parameter. With the default maps, AND test signals are 0 in phases 1 and 2 and 1 in phases 0 and 3. OR test signals are 1 in phases 2 and 3 and 0 in phases 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a session when idle |
| pat_count_i | input | CNT_W | Patterns per phase, sampled at start |
| and_line_i | input | NUM_AND | Functional lines into the AND-type cells |
| or_line_i | input | NUM_OR | Functional lines into the OR-type cells |
| and_line_o | output | NUM_AND | AND-type cell outputs |
| or_line_o | output | NUM_OR | OR-type cell outputs |
| and_tsig_o | output | NUM_AND | Per-cell AND test signals |
| or_tsig_o | output | NUM_OR | Per-cell OR test signals |
| phase_o | output | 2 | Current phase |
| active_o | output | 1 | Session in progress |
| done_o | output | 1 | Session finished |

## Verification
The critical same-cycle collision is a start request arriving on the very edge that ends the final pattern of phase 3, which is the edge where done rises. The bench raises `start_i` for exactly that edge, and also pulses it in the middle of a session and changes `pat_count_i` mid-session. A scoreboard queue holds the expected phase, flags, test signals and line outputs for every cycle after the start. The edge must show done rising with the session left stopped, which proves the start was ignored. A later start must then be accepted normally.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PHASE_W    = $clog2(NUM_PHASES);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_PHASES - 1);

  typedef logic [PHASE_W-1:0] phase_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  // limit value for a count: zero is treated as one pattern
  function automatic logic [31:0] count_to_limit(input logic [31:0] cnt);
    return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
  endfunction
endpackage

// File: rtl/cpt_seq.sv
module cpt_seq
  import cpt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pat_count_i,
  output phase_t           phase_o,
  output logic             active_o,
  output logic             done_o
);
  seq_state_e       state_q, state_d;
  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             phase_end;

  assign phase_end = (cnt_q == lim_q);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    unique case (state_q)
      SEQ_IDLE, SEQ_DONE: begin
        if (start_i) begin
          state_d = SEQ_RUN;
          phase_d = '0;
          cnt_d   = '0;
          lim_d   = CNT_W'(count_to_limit(32'(pat_count_i)));
        end
      end
      SEQ_RUN: begin
        if (phase_end) begin
          cnt_d = '0;
          if (phase_q == LAST_PHASE) state_d = SEQ_DONE;
          else                       phase_d = phase_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      phase_q <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
    end
  end

  assign phase_o  = phase_q;
  assign active_o = (state_q == SEQ_RUN);
  assign done_o   = (state_q == SEQ_DONE);
endmodule

// File: rtl/cpt_phase_decode.sv
module cpt_phase_decode
  import cpt_pkg::*;
#(
  parameter int                        NUM_PTS  = 4,
  parameter logic [4*NUM_PTS-1:0]      MAP      = {NUM_PTS{4'b0110}},
  parameter logic                      FORCE_LV = 1'b0
) (
  input  phase_t               phase_i,
  input  logic                 active_i,
  output logic [NUM_PTS-1:0]   tsig_o
);
  for (genvar i = 0; i < NUM_PTS; i++) begin : g_pt
    logic [NUM_PHASES-1:0] mask;
    logic                  forcing;
    assign mask    = MAP[NUM_PHASES*i +: NUM_PHASES];
    assign forcing = active_i & mask[phase_i];
    assign tsig_o[i] = forcing ? FORCE_LV : ~FORCE_LV;
  end
endmodule

// File: rtl/cpt_cells.sv
module cpt_and_cell (
  input  logic line_i,
  input  logic tsig_i,
  output logic line_o
);
  assign line_o = line_i & tsig_i;
endmodule

module cpt_or_cell (
  input  logic line_i,
  input  logic tsig_i,
  output logic line_o
);
  assign line_o = line_i | tsig_i;
endmodule

// File: rtl/cpt_session_ctrl.sv
module cpt_session_ctrl
  import cpt_pkg::*;
#(
  parameter int                   NUM_AND = 4,
  parameter int                   NUM_OR  = 4,
  parameter int                   CNT_W   = 8,
  parameter logic [4*NUM_AND-1:0] AND_MAP = {NUM_AND{4'b0110}},
  parameter logic [4*NUM_OR-1:0]  OR_MAP  = {NUM_OR{4'b1100}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   pat_count_i,
  input  logic [NUM_AND-1:0] and_line_i,
  input  logic [NUM_OR-1:0]  or_line_i,
  output logic [NUM_AND-1:0] and_line_o,
  output logic [NUM_OR-1:0]  or_line_o,
  output logic [NUM_AND-1:0] and_tsig_o,
  output logic [NUM_OR-1:0]  or_tsig_o,
  output logic [1:0]         phase_o,
  output logic               active_o,
  output logic               done_o
);
  phase_t phase;
  logic   active;

  cpt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pat_count_i (pat_count_i),
    .phase_o     (phase),
    .active_o    (active),
    .done_o      (done_o)
  );

  cpt_phase_decode #(.NUM_PTS(NUM_AND), .MAP(AND_MAP), .FORCE_LV(1'b0)) u_and_dec (
    .phase_i  (phase),
    .active_i (active),
    .tsig_o   (and_tsig_o)
  );

  cpt_phase_decode #(.NUM_PTS(NUM_OR), .MAP(OR_MAP), .FORCE_LV(1'b1)) u_or_dec (
    .phase_i  (phase),
    .active_i (active),
    .tsig_o   (or_tsig_o)
  );

  for (genvar i = 0; i < NUM_AND; i++) begin : g_and
    cpt_and_cell u_cell (.line_i(and_line_i[i]), .tsig_i(and_tsig_o[i]), .line_o(and_line_o[i]));
  end

  for (genvar j = 0; j < NUM_OR; j++) begin : g_or
    cpt_or_cell u_cell (.line_i(or_line_i[j]), .tsig_i(or_tsig_o[j]), .line_o(or_line_o[j]));
  end

  assign phase_o  = phase;
  assign active_o = active;
endmodule

// File: rtl/cpt_session_chk.sv
module cpt_session_chk #(
  parameter int NUM_AND = 4,
  parameter int NUM_OR  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [NUM_AND-1:0] and_line_o,
  input logic [NUM_OR-1:0]  or_line_o,
  input logic [NUM_AND-1:0] and_tsig_o,
  input logic [NUM_OR-1:0]  or_tsig_o,
  input logic [1:0]         phase_o,
  input logic               active_o,
  input logic               done_o
);
  // R2
  session_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> (phase_o == 2'd0 && !done_o));

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o)) |-> (phase_o == $past(phase_o) || phase_o == $past(phase_o) + 2'd1));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!active_o && phase_o == 2'd3));

  // R4
  end_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> done_o);

  // R5
  and_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (and_line_o & ~and_tsig_o) == '0);

  // R6
  or_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~or_line_o & or_tsig_o) == '0);

  // R7
  idle_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (&and_tsig_o && or_tsig_o == '0));

  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && start_i && phase_o != 2'd3) |=> active_o);
endmodule

bind cpt_session_ctrl cpt_session_chk #(.NUM_AND(NUM_AND), .NUM_OR(NUM_OR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .and_line_o (and_line_o),
  .or_line_o  (or_line_o),
  .and_tsig_o (and_tsig_o),
  .or_tsig_o  (or_tsig_o),
  .phase_o    (phase_o),
  .active_o   (active_o),
  .done_o     (done_o)
);

// File: tb/sim_cpt_session_ctrl.sv
`timescale 1ns/1ps
module sim_cpt_session_ctrl;
  localparam int NA = 4;
  localparam int NO = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] pat_count_i = '0;
  logic [NA-1:0] and_line_i = '0;
  logic [NO-1:0] or_line_i = '0;
  logic [NA-1:0] and_line_o, and_tsig_o;
  logic [NO-1:0] or_line_o, or_tsig_o;
  logic [1:0]    phase_o;
  logic          active_o, done_o;

  always #2.5 clk = ~clk;

  cpt_session_ctrl #(.NUM_AND(NA), .NUM_OR(NO), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pat_count_i(pat_count_i),
    .and_line_i(and_line_i), .or_line_i(or_line_i),
    .and_line_o(and_line_o), .or_line_o(or_line_o),
    .and_tsig_o(and_tsig_o), .or_tsig_o(or_tsig_o),
    .phase_o(phase_o), .active_o(active_o), .done_o(done_o));

  typedef struct {
    logic [1:0]    phase;
    logic          active;
    logic          done;
    logic [NA-1:0] and_ts;
    logic [NO-1:0] or_ts;
    logic [NA-1:0] and_out;
    logic [NO-1:0] or_out;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  // R8: AND forces in phases 1,2; OR forces in phases 2,3 (default maps)
  function automatic exp_t model(input logic act, input logic dn, input logic [1:0] ph);
    exp_t e;
    logic af, of;
    af = act && (ph == 2'd1 || ph == 2'd2);
    of = act && (ph == 2'd2 || ph == 2'd3);
    e.phase   = ph;
    e.active  = act;
    e.done    = dn;
    e.and_ts  = af ? '0 : '1;
    e.or_ts   = of ? '1 : '0;
    e.and_out = and_line_i & e.and_ts;
    e.or_out  = or_line_i | e.or_ts;
    return e;
  endfunction

  task automatic compare(input string tag, input exp_t e);
    checks++;
    if (phase_o !== e.phase || active_o !== e.active || done_o !== e.done ||
        and_tsig_o !== e.and_ts || or_tsig_o !== e.or_ts ||
        and_line_o !== e.and_out || or_line_o !== e.or_out) begin
      errors++;
      $display("FAIL %s: got ph=%0d act=%0b dn=%0b ats=%b ots=%b ao=%b oo=%b exp ph=%0d act=%0b dn=%0b ats=%b ots=%b ao=%b oo=%b",
               tag, phase_o, active_o, done_o, and_tsig_o, or_tsig_o, and_line_o, or_line_o,
               e.phase, e.active, e.done, e.and_ts, e.or_ts, e.and_out, e.or_out);
    end
  endtask

  // monitor: one expected item per clock edge after a start
  string mon_tag = "R3";
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compare(mon_tag, e);
      end
    end
  end

  // driver: start a session with count n; extra_edge>0 pulses start at that edge
  task automatic run_session(input int n, input int extra_edge, input logic [CW-1:0] late_cnt,
                             input logic [NA-1:0] ain, input logic [NO-1:0] oin, input string tag);
    int eff;
    eff = (n == 0) ? 1 : n;
    @(negedge clk);
    and_line_i  = ain;
    or_line_i   = oin;
    pat_count_i = CW'(n);
    start_i     = 1'b1;
    mon_tag     = tag;
    for (int j = 1; j <= 4*eff; j++)
      exp_q.push_back(model(1'b1, 1'b0, 2'((j-1)/eff)));
    exp_q.push_back(model(1'b0, 1'b1, 2'd3));
    exp_q.push_back(model(1'b0, 1'b1, 2'd3));
    for (int k = 1; k <= 4*eff + 1; k++) begin
      @(negedge clk);
      start_i     = (extra_edge == k + 1);
      pat_count_i = late_cnt;
    end
    start_i = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!finished && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    and_line_i = 4'b1011;
    or_line_i  = 4'b0100;
    repeat (3) @(posedge clk);
    #1;
    // R1 and R7: reset state, transparent lines
    compare("R1", model(1'b0, 1'b0, 2'd0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare("R7", model(1'b0, 1'b0, 2'd0));

    // R3, R5, R6, R8: three patterns per phase
    run_session(3, 0, 8'd3, 4'b1111, 4'b0000, "R8");
    // R4: done holds with idle transparency
    repeat (3) @(negedge clk);
    compare("R4", model(1'b0, 1'b1, 2'd3));
    // R2: restart after done, one pattern per phase, new line values
    run_session(1, 0, 8'd1, 4'b0101, 4'b1010, "R2");
    // R3: zero count acts as one
    run_session(0, 0, 8'd0, 4'b1110, 4'b0001, "R3");
    // R2: mid-session start and count change ignored
    run_session(2, 4, 8'd7, 4'b1001, 4'b0110, "R2");
    // R4: start on the edge that ends phase 3 is ignored, done rises
    run_session(2, 9, 8'd5, 4'b0011, 4'b1100, "R4");
    @(negedge clk);
    compare("R4", model(1'b0, 1'b1, 2'd3));
    // R5/R6: line changes while idle pass through
    and_line_i = 4'b0110;
    or_line_i  = 4'b1001;
    #1;
    compare("R7", model(1'b0, 1'b1, 2'd3));
    // R3: longer session
    run_session(5, 0, 8'd1, 4'b1111, 4'b0000, "R3");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule